// File: doc/BRIEF.md
# One-Longword Write-Through Store Buffer

This block sits between an execution unit and a write-through data cache. Every data write goes to memory. A single entry holds one longword write: its address, its 32-bit data and four byte enables. When the entry is empty, the requester hands over its write in one cycle and carries on without waiting. The entry then drains to memory through a valid/ready handshake.

A second write that arrives before the memory has acknowledged the first is held off with a combinational stall until the entry frees. The entry frees on the acknowledge cycle, and a waiting write is taken in that same cycle. The drain takes a fixed six cycles, so two writes issued closer together than that stall, and writes spaced six or more cycles apart never do.

The cache sees every write. The cache answers with a hit flag in the cycle the write is taken. On a hit, the block sends the buffered data with its byte enables to the cache one cycle later. On a miss, no cache update is issued, so nothing is allocated. A counter records every cycle a write is held off.

Top module: `wt_store_buffer`

## Requirements
- R1: While the entry waits for the memory acknowledge (`mem_valid` high, `mem_ready` low), `mem_addr`, `mem_data` and `mem_be` stay unchanged.
- R2: Every accepted write reaches memory in acceptance order, with its own address, data and byte enables. This holds whether the write hit or missed in the cache. Bit i of a byte enable covers data bits 8i+7 down to 8i.
- R3: A write presented while the entry is empty is accepted in that cycle: `wr_stall` is low, and `mem_valid` is high in the next cycle.
- R4: `wr_stall` is high in any cycle where `wr_valid` is high, the entry is occupied and `mem_ready` is low. It stays high until the entry frees.
- R5: In the cycle `mem_ready` acknowledges the entry, a waiting write is accepted. With a memory that acknowledges in the sixth cycle of `mem_valid`, a write issued d cycles after the previous one stalls 6-d cycles for d below 6 and no cycles for d of 6 or more.
- R6: In the cycle after a write is accepted with `cache_hit` high, `cache_upd_en` pulses with that write's address, data and byte enables. An accepted write with `cache_hit` low produces no cache update, and the cached word is left as it was.
- R7: `stall_count` goes up by one in each cycle `wr_stall` is high and holds its value otherwise.
- R8: After reset the entry is empty: `mem_valid`, `cache_upd_en` and `wr_stall` are low and `stall_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request from the execution unit |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| wr_stall | output | 1 | Request is held off this cycle |
| cache_lookup_addr | output | AW | Address presented to the cache tag check |
| cache_hit | input | 1 | Cache hit for the lookup address |
| cache_upd_en | output | 1 | Cache data update strobe |
| cache_upd_addr | output | AW | Cache update address |
| cache_upd_data | output | 32 | Cache update data |
| cache_upd_be | output | 4 | Cache update byte enables |
| mem_valid | output | 1 | Buffered write offered to memory |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ready | input | 1 | Memory acknowledges the buffered write |
| stall_count | output | CW | Count of cycles a write was held off |

## Verification
The bench sends pairs of writes with spacings from one to eight cycles. This separates the stall depths 5 down to 1 from the stall-free spacings, and it tests the take-on-acknowledge cycle at spacing 6. Pairs alternate cache hits and misses, so a model that updates or allocates on misses shows up in the cache image. A further sweep writes all sixteen byte-enable patterns into the same words. This checks that byte enables are merged correctly in both the memory image and the cache image.

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  output logic          wr_stall,
  output logic [AW-1:0] cache_lookup_addr,
  input  logic          cache_hit,
  output logic          cache_upd_en,
  output logic [AW-1:0] cache_upd_addr,
  output logic [31:0]   cache_upd_data,
  output logic [3:0]    cache_upd_be,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_data,
  output logic [3:0]    mem_be,
  input  logic          mem_ready,
  output logic [CW-1:0] stall_count
);

  logic          full;
  logic          take;
  logic [AW-1:0] e_addr;
  logic [31:0]   e_data;
  logic [3:0]    e_be;

  assign take     = wr_valid & (~full | mem_ready);
  assign wr_stall = wr_valid & full & ~mem_ready;

  assign cache_lookup_addr = wr_addr;

  assign mem_valid = full;
  assign mem_addr  = e_addr;
  assign mem_data  = e_data;
  assign mem_be    = e_be;

  assign cache_upd_addr = e_addr;
  assign cache_upd_data = e_data;
  assign cache_upd_be   = e_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full         <= 1'b0;
      cache_upd_en <= 1'b0;
      stall_count  <= '0;
      e_addr       <= '0;
      e_data       <= '0;
      e_be         <= '0;
    end else begin
      full         <= take | (full & ~mem_ready);
      cache_upd_en <= take & cache_hit;
      if (wr_stall) stall_count <= stall_count + 1'b1;
      if (take) begin
        e_addr <= wr_addr;
        e_data <= wr_data;
        e_be   <= wr_be;
      end
    end
  end

endmodule

// File: rtl/wt_store_buffer_chk.sv
module wt_store_buffer_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_stall,
  input logic          cache_hit,
  input logic          cache_upd_en,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_data,
  input logic [3:0]    mem_be,
  input logic          mem_ready,
  input logic [CW-1:0] stall_count
);

  a_r1_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  a_r3_free_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !mem_valid |-> !wr_stall);

  a_r3_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_stall |=> mem_valid);

  a_r4_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> mem_valid && !mem_ready);

  a_r5_ack_takes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |-> !wr_stall);

  a_r6_upd_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_stall && !cache_hit |=> !cache_upd_en);

  a_r6_upd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_stall && cache_hit |=> cache_upd_en);

  a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |=> stall_count == $past(stall_count) + 1'b1);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stall |=> $stable(stall_count));

endmodule

bind wt_store_buffer wt_store_buffer_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_stall(wr_stall),
  .cache_hit(cache_hit), .cache_upd_en(cache_upd_en), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
  .mem_ready(mem_ready), .stall_count(stall_count)
);

// File: tb/wt_store_buffer_test.sv
module wt_store_buffer_test;
  localparam int AW  = 32;
  localparam int CW  = 16;
  localparam int LAT = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic          wr_stall;
  logic [AW-1:0] cache_lookup_addr;
  logic          cache_hit;
  logic          cache_upd_en;
  logic [AW-1:0] cache_upd_addr;
  logic [31:0]   cache_upd_data;
  logic [3:0]    cache_upd_be;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data;
  logic [3:0]    mem_be;
  logic          mem_ready;
  logic [CW-1:0] stall_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wt_store_buffer #(.AW(AW), .CW(CW)) uut (.*);

  // cache: words with address bit 8 clear are resident
  assign cache_hit = ~cache_lookup_addr[8];

  logic [3:0] hc;
  assign mem_ready = mem_valid && (hc == LAT - 1);

  logic [31:0] mem_img [128];
  logic [31:0] cache_img [64];
  logic [31:0] exp_mem [128];
  logic [31:0] exp_cache [64];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] b);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (b[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
      for (int i = 0; i < 128; i++) mem_img[i] <= '0;
      for (int i = 0; i < 64; i++) cache_img[i] <= '0;
    end else begin
      hc <= (mem_valid && !mem_ready) ? hc + 1'b1 : '0;
      if (mem_valid && mem_ready)
        mem_img[mem_addr[8:2]] <= merge(mem_img[mem_addr[8:2]], mem_data, mem_be);
      if (cache_upd_en)
        cache_img[cache_upd_addr[7:2]] <= merge(cache_img[cache_upd_addr[7:2]], cache_upd_data, cache_upd_be);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b, output int st);
    st = 0;
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = b;
    #1;
    while (wr_stall) begin
      st++;
      @(posedge clk); @(negedge clk); #1;
    end
    exp_mem[a[8:2]] = merge(exp_mem[a[8:2]], d, b);
    if (!a[8]) exp_cache[a[7:2]] = merge(exp_cache[a[7:2]], d, b);
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int st;
    logic [CW-1:0] c0;
    for (int i = 0; i < 128; i++) exp_mem[i] = '0;
    for (int i = 0; i < 64; i++) exp_cache[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 mem_valid", {31'd0, mem_valid}, 0);
    check("R8 cache_upd_en", {31'd0, cache_upd_en}, 0);
    check("R8 stall", {31'd0, wr_stall}, 0);
    check("R8 stall_count", {16'd0, stall_count}, 0);

    // R3/R4/R5/R7: spacing sweep
    for (int d = 1; d <= 8; d++) begin
      logic [31:0] aa = {23'd0, d[0], 2'(d), 6'd0} + 32'(d*4);
      logic [31:0] ab = aa ^ 32'h100;
      idle(10);
      c0 = stall_count;
      put(aa, 32'h1111_0000 + 32'(d), 4'hF, st);
      check($sformatf("R3 first write stall d=%0d", d), st, 0);
      // R3: mem_valid visible in the cycle after acceptance
      check($sformatf("R3 mem_valid d=%0d", d), {31'd0, mem_valid}, 1);
      idle(d - 1);
      put(ab, 32'h2222_0000 + 32'(d), 4'(d * 3), st);
      check($sformatf("R5 stall cycles d=%0d", d), st, (d < LAT) ? LAT - d : 0);
      check($sformatf("R7 count delta d=%0d", d), 32'(stall_count - c0), (d < LAT) ? LAT - d : 0);
    end

    // R6: hit/miss and byte enable sweep on shared words
    for (int b = 0; b < 16; b++) begin
      idle(2);
      put(32'h0000_0040, 32'hA0B0C0D0 ^ 32'(b * 32'h01010101), 4'(b), st);
      put(32'h0000_0140, 32'h5060_7080 + 32'(b), 4'(15 - b), st);
    end

    // R6: no update after a miss in the cycle that follows
    idle(10);
    put(32'h0000_0180, 32'hDEAD_BEEF, 4'hF, st);
    check("R6 no update on miss", {31'd0, cache_upd_en}, 0);
    idle(10);
    put(32'h0000_0080, 32'hCAFE_F00D, 4'h5, st);
    check("R6 update on hit", {31'd0, cache_upd_en}, 1);
    check("R6 update be", {28'd0, cache_upd_be}, 32'h5);

    // R1 is held by assertion; R2 image compare
    idle(12);
    for (int i = 0; i < 128; i++) check($sformatf("R2 mem word %0d", i), mem_img[i], exp_mem[i]);
    for (int i = 0; i < 64; i++) check($sformatf("R6 cache word %0d", i), cache_img[i], exp_cache[i]);
    finish_run();
  end
endmodule